// File: doc/BRIEF.md
# Signed PWM Motor Drive Generator

This block turns a signed two's-complement drive demand into a fixed-frequency pulse-width-modulated enable line and a pair of H-bridge direction lines. A divider makes a one-cycle step enable every `CE_DIV` system clocks. A `WIDTH`-bit step counter advances on that enable, so one fundamental period lasts `2^WIDTH` steps. With `WIDTH = 10`, `CE_DIV = 5` and a 50 MHz clock, this gives a 10 MHz step rate and a period frequency of about 9.77 kHz. For short simulations the width can be reduced, for example to 4.

The demand is taken in only at the clock edge that ends a period. At that edge its sign selects the direction lines and its magnitude becomes the pulse length for the whole next period. A demand that changes mid-period therefore never produces a split or glitched pulse.

A three-state phase machine drives the outputs:
- `PH_IDLE` is entered on reset. All outputs are low. Transition *first boundary*: at the first period end the machine moves to `PH_HIGH` if the captured magnitude is non-zero, otherwise to `PH_LOW`.
- `PH_HIGH` drives the pulse. Transition *pulse done*: when the step counter is about to reach the captured magnitude, the machine moves to `PH_LOW`.
- `PH_LOW` holds the pulse off for the rest of the period.
- Transition *period restart*: from either active state, each period end re-enters `PH_HIGH` or `PH_LOW` according to the newly captured magnitude.
- Transition *reset*: synchronous reset returns to `PH_IDLE` from any state.

Top module: `spwm_drive`

## Requirements
- R1: While reset is high, and after its release until the first period end, `pwm_out`, `dir_a` and `dir_b` are all 0.
- R2: The step counter advances once every `CE_DIV` clocks, so one period lasts `CE_DIV * 2^WIDTH` clocks; the first period ends at the `CE_DIV * 2^WIDTH`-th rising edge after reset release.
- R3: In a period whose captured magnitude is m, `pwm_out` is 1 for the first m steps (m * `CE_DIV` clocks), starting the cycle after the period end, and 0 for the rest of the period.
- R4: The demand is sampled only at the edge that ends a period; a demand change at any other time has no effect on any output until the following period end.
- R5: A captured demand whose most significant bit is 0 gives `dir_a`=1, `dir_b`=0; a most significant bit of 1 gives `dir_a`=0, `dir_b`=1; both lines are never 1 together.
- R6: The magnitude of a negative demand d is -d. The most negative demand -2^(WIDTH-1) gives 2^(WIDTH-1) high steps (half duty). A zero demand keeps `pwm_out` at 0 for the whole period with `dir_a`=1.
- R7: Asserting the synchronous reset during operation clears all outputs at the next edge, and timing restarts as in R1 and R2 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| demand | input | WIDTH | Signed two's-complement drive demand |
| pwm_out | output | 1 | Pulse-width-modulated bridge enable |
| dir_a | output | 1 | Direction line, high for forward drive |
| dir_b | output | 1 | Direction line, high for reverse drive |

## Verification
A wrong divider or step count shows as pulse edges that are displaced by whole steps, and the displacement appears within the first active period. A bad capture register shows either as a pulse length that changes in the same period as a demand change, or as a wrong length or direction for a full period after the boundary. The bench predicts every cycle's outputs from the edge count and the demand seen at each period end, so any such error is reported in the cycle it first appears.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    // Phase of the output pulse within a fundamental period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;

endpackage

// File: rtl/spwm_ce_div.sv
// Step-enable divider: one-cycle pulse every DIV clocks (DIV >= 2).
module spwm_ce_div #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst,
    output logic ce
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    assign ce = (div_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (ce) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R2
    ce_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce);

endmodule

// File: rtl/spwm_period.sv
// Step counter, magnitude extraction and period-end demand capture.
module spwm_period #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] demand,
    output logic [WIDTH-1:0] step,
    output logic             wrap,
    output logic [WIDTH-1:0] mag_in,
    output logic [WIDTH-1:0] mag_q,
    output logic             neg_q
);
    localparam logic [WIDTH-1:0] STEP_LAST = '1;

    assign wrap   = ce && (step == STEP_LAST);
    assign mag_in = demand[WIDTH-1] ? (WIDTH'(0) - demand) : demand;

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= '0;
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            if (ce) begin
                step <= step + 1'b1;
            end
            if (wrap) begin
                mag_q <= mag_in;
                neg_q <= demand[WIDTH-1];
            end
        end
    end

    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(step));

    // R4
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(mag_q) && $stable(neg_q)));

endmodule

// File: rtl/spwm_drive.sv
// Signed PWM generator with H-bridge direction lines.
module spwm_drive
    import spwm_pkg::*;
#(
    parameter int WIDTH  = 10,
    parameter int CE_DIV = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] demand,
    output logic             pwm_out,
    output logic             dir_a,
    output logic             dir_b
);
    logic             ce;
    logic             wrap;
    logic             neg_q;
    logic [WIDTH-1:0] step;
    logic [WIDTH-1:0] mag_in;
    logic [WIDTH-1:0] mag_q;
    logic [WIDTH:0]   step_next;
    phase_t           phase_q;
    phase_t           phase_d;

    spwm_ce_div #(.DIV(CE_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .ce  (ce)
    );

    spwm_period #(.WIDTH(WIDTH)) u_period (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .demand (demand),
        .step   (step),
        .wrap   (wrap),
        .mag_in (mag_in),
        .mag_q  (mag_q),
        .neg_q  (neg_q)
    );

    assign step_next = {1'b0, step} + (WIDTH+1)'(1);

    // Next-phase logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (wrap) phase_d = (mag_in != '0) ? PH_HIGH : PH_LOW;
            end
            PH_HIGH: begin
                if (wrap) begin
                    phase_d = (mag_in != '0) ? PH_HIGH : PH_LOW;
                end else if (ce && (step_next == {1'b0, mag_q})) begin
                    phase_d = PH_LOW;
                end
            end
            PH_LOW: begin
                if (wrap) phase_d = (mag_in != '0) ? PH_HIGH : PH_LOW;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    // Outputs
    always_comb begin
        pwm_out = (phase_q == PH_HIGH);
        dir_a   = (phase_q != PH_IDLE) && !neg_q;
        dir_b   = (phase_q != PH_IDLE) &&  neg_q;
    end

    // R5
    dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dir_a && dir_b));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_out |-> (dir_a || dir_b));

    // R3
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> $past(wrap));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!pwm_out && !dir_a && !dir_b));

endmodule

// File: tb/spwm_drive_tb.sv
module spwm_drive_tb;
    localparam int W      = 4;
    localparam int DIV    = 3;
    localparam int STEPS  = 1 << W;
    localparam int PCLK   = DIV * STEPS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] demand = '0;
    logic         pwm_out, dir_a, dir_b;

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";
    bit    done  = 1'b0;

    // model state
    int    edges  = 0;
    bit    active = 1'b0;
    int    cap_mag = 0;
    bit    cap_neg = 1'b0;

    bit [2:0] exp_q[$];
    string    tag_q[$];

    always #5 clk = ~clk;

    spwm_drive #(.WIDTH(W), .CE_DIV(DIV)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .demand  (demand),
        .pwm_out (pwm_out),
        .dir_a   (dir_a),
        .dir_b   (dir_b)
    );

    // Scoreboard producer: expected outputs after each rising edge
    always @(posedge clk) begin
        int s;
        bit ep, ea, eb;
        if (rst) begin
            edges  = 0;
            active = 1'b0;
        end else begin
            edges = edges + 1;
            if (edges % PCLK == 0) begin
                int d;
                d = $signed(demand);
                cap_mag = (d < 0) ? -d : d;
                cap_neg = demand[W-1];
                active  = 1'b1;
            end
        end
        s  = (edges / DIV) % STEPS;
        ep = active && (s < cap_mag);
        ea = active && !cap_neg;
        eb = active && cap_neg;
        exp_q.push_back({ep, ea, eb});
        tag_q.push_back(tag);
    end

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit [2:0] e;
            string    t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({pwm_out, dir_a, dir_b} !== e) begin
                bad++;
                $display("FAIL %s: {pwm,dir_a,dir_b} actual=%b expected=%b at t=%0t",
                         t, {pwm_out, dir_a, dir_b}, e, $time);
            end
            total++;
            if (dir_a && dir_b) begin
                bad++;
                $display("FAIL R5: both direction lines high actual=11 expected=not 11");
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state and first idle period
        wait_cyc(4);
        rst = 1'b0;
        demand = W'(5);
        wait_cyc(PCLK);
        // R3: positive pulse length 5 steps
        tag = "R3";
        wait_cyc(2 * PCLK);
        // R2: step timing over a full period
        tag = "R2";
        wait_cyc(PCLK);
        // R4: mid-period change must not alter the running pulse
        wait_cyc(20);
        tag = "R4";
        demand = W'(-3);
        wait_cyc(PCLK - 20);
        // R5: reverse direction after the boundary
        tag = "R5";
        wait_cyc(PCLK);
        // R6: most negative value, then zero
        tag = "R6";
        demand = W'(-8);
        wait_cyc(2 * PCLK);
        demand = '0;
        wait_cyc(2 * PCLK);
        // R3: largest positive value
        tag = "R3";
        demand = W'(7);
        wait_cyc(2 * PCLK);
        // R7: reset during operation and restart
        wait_cyc(10);
        tag = "R7";
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        demand = W'(2);
        wait_cyc(2 * PCLK + 5);
        wait_cyc(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(10 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule